// File: doc/BRIEF.md
# UART FIFO Service Interrupt Controller

This block holds the character queues between a UART's serial shifters and software. Received characters arrive from a deserializer together with a framing-error flag and a parity-error flag. They are stored in a 32-entry receive queue, and software reads them back through a show-ahead pop port. Bytes that software writes go into a 32-entry transmit queue, and the serializer drains that queue through a head/valid/pop port.

The block raises service requests so that software can move characters in bursts instead of one interrupt per byte. Receive service is requested when the receive queue fills to a programmed high-water level. It is also requested when characters have waited unread for eight character periods. Transmit service is requested once the number of bytes still queued falls to a programmed low-water level. The threshold therefore counts bytes remaining, not free slots. A break report from the receiver is latched as well. Each of these four sources has its own enable, and one combined interrupt line is driven. Event flags are cleared by writing ones to them. A character-period tick comes in from outside.

Top module: `sio_fifo_svc`

## Requirements
- R1: The receive queue holds 32 entries in arrival order. `rx_rdata` shows the oldest entry as {parity error (bit 9), framing error (bit 8), data (bits 7:0)}, and `rx_pop` removes it.
- R2: Status bit 0 (receive ready) is high in every cycle in which `rx_level` is greater than or equal to `cfg_rx_thr`.
- R3: Status bit 2 (transmit ready) is high in every cycle in which `tx_level` is less than or equal to `cfg_tx_thr`.
- R4: Status bit 1 (aging) sets after 8 `char_tick` pulses during which the receive queue stayed non-empty with no push and no pop. Any receive push or pop restarts the count, and the count does not run while the queue is empty.
- R5: Status bit 3 (break) sets when `rx_break` is high and stays set until it is cleared, whatever the queue state.
- R6: A cycle with `sts_wr` high clears each event bit (1, 3, 4, 5) whose `sts_wdata` bit is 1. Writing to bits 0 and 2 has no effect. An event arriving in the same cycle as its clear leaves the bit set.
- R7: `irq` equals the OR of `status[3:0] & irq_en`, where `irq_en` bit n enables status bit n.
- R8: A receive push into a full queue discards the character, leaves the stored entries unchanged and sets status bit 4 (overrun).
- R9: A transmit push into a full queue is dropped and sets status bit 5 (overflow).
- R10: `data_ready` is high exactly when the receive queue is non-empty, independent of thresholds.
- R11: The transmit queue holds 32 bytes in order. `tx_data` shows the oldest byte with `tx_valid` high, and a `tx_pop` while empty changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 1 | Deserializer delivers a character |
| rx_data | input | 8 | Received character |
| rx_frm_err | input | 1 | Framing error of the character |
| rx_par_err | input | 1 | Parity error of the character |
| rx_break | input | 1 | Break condition seen by the receiver |
| char_tick | input | 1 | One pulse per character period |
| rx_pop | input | 1 | Software reads the oldest receive entry |
| rx_rdata | output | 10 | Oldest receive entry with error flags |
| rx_level | output | 6 | Receive queue occupancy |
| data_ready | output | 1 | Receive queue non-empty |
| tx_push | input | 1 | Software writes a transmit byte |
| tx_wdata | input | 8 | Transmit byte |
| tx_pop | input | 1 | Serializer takes the oldest byte |
| tx_data | output | 8 | Oldest transmit byte |
| tx_valid | output | 1 | Transmit queue non-empty |
| tx_level | output | 6 | Transmit queue occupancy |
| cfg_rx_thr | input | 6 | Receive high-water level |
| cfg_tx_thr | input | 6 | Transmit low-water level (bytes remaining) |
| irq_en | input | 4 | Per-source interrupt enables |
| sts_wr | input | 1 | Write-one-to-clear strobe |
| sts_wdata | input | 6 | Bits to clear |
| status | output | 6 | Status flags |
| irq | output | 1 | Combined interrupt |

## Verification
A write-one-to-clear and a new event for the same flag can land in the same clock. Set must win, or a break or overrun that arrives while software is acknowledging the earlier one would be lost. The bench drives `rx_break` together with a clear of bit 3, and a full-queue push together with a clear of bit 4. It expects both bits still set at the next sample, and expects a lone clear afterwards to empty them. It also pushes in the cycle on which the eighth tick would have fired aging, and expects the timer to restart rather than fire.

// File: rtl/sio_svc_pkg.sv
package sio_svc_pkg;
  localparam int ST_W      = 6;
  localparam int ST_RXRDY  = 0;
  localparam int ST_AGE    = 1;
  localparam int ST_TXRDY  = 2;
  localparam int ST_BRK    = 3;
  localparam int ST_RXOVR  = 4;
  localparam int ST_TXOVF  = 5;
  localparam int IRQ_SRCS  = 4;
  localparam logic [ST_W-1:0] EV_MASK = 6'b111010;
endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = wr_q + AW'(1);
    if (do_pop)  rd_d = rd_q + AW'(1);
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata;
  end

  assign rdata = mem[rd_q];
  assign count = cnt_q;
endmodule

// File: rtl/sio_age_timer.sv
module sio_age_timer #(
  parameter int AGE_TICKS = 8,
  localparam int TW       = $clog2(AGE_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  input  logic occupied,
  output logic hit
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          run;

  assign run = tick & occupied & ~restart & (cnt_q != TW'(AGE_TICKS));
  assign hit = run & (cnt_q == TW'(AGE_TICKS - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !occupied) cnt_d = '0;
    else if (run)             cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sio_status.sv
module sio_status
  import sio_svc_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CW-1:0]       rx_cnt,
  input  logic [CW-1:0]       tx_cnt,
  input  logic [CW-1:0]       rx_thr,
  input  logic [CW-1:0]       tx_thr,
  input  logic                age_ev,
  input  logic                brk_ev,
  input  logic                rx_ovr_ev,
  input  logic                tx_ovf_ev,
  input  logic                clr_wr,
  input  logic [ST_W-1:0]     clr_mask,
  input  logic [IRQ_SRCS-1:0] irq_en,
  output logic [ST_W-1:0]     status,
  output logic                irq
);
  logic [ST_W-1:0] ev_q, ev_d, ev_set, clr, lvl;

  always_comb begin
    ev_set            = '0;
    ev_set[ST_AGE]    = age_ev;
    ev_set[ST_BRK]    = brk_ev;
    ev_set[ST_RXOVR]  = rx_ovr_ev;
    ev_set[ST_TXOVF]  = tx_ovf_ev;
    clr               = clr_wr ? (clr_mask & EV_MASK) : '0;
    ev_d              = ((ev_q & ~clr) | ev_set) & EV_MASK;
    lvl               = '0;
    lvl[ST_RXRDY]     = (rx_cnt >= rx_thr);
    lvl[ST_TXRDY]     = (tx_cnt <= tx_thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= ev_d;
  end

  assign status = ev_q | lvl;
  assign irq    = |(status[IRQ_SRCS-1:0] & irq_en);
endmodule

// File: rtl/sio_fifo_svc.sv
module sio_fifo_svc
  import sio_svc_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int DW        = 8,
  parameter int AGE_TICKS = 8,
  localparam int CW       = $clog2(DEPTH) + 1,
  localparam int RW       = DW + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_push,
  input  logic [DW-1:0]       rx_data,
  input  logic                rx_frm_err,
  input  logic                rx_par_err,
  input  logic                rx_break,
  input  logic                char_tick,
  input  logic                rx_pop,
  output logic [RW-1:0]       rx_rdata,
  output logic [CW-1:0]       rx_level,
  output logic                data_ready,
  input  logic                tx_push,
  input  logic [DW-1:0]       tx_wdata,
  input  logic                tx_pop,
  output logic [DW-1:0]       tx_data,
  output logic                tx_valid,
  output logic [CW-1:0]       tx_level,
  input  logic [CW-1:0]       cfg_rx_thr,
  input  logic [CW-1:0]       cfg_tx_thr,
  input  logic [IRQ_SRCS-1:0] irq_en,
  input  logic                sts_wr,
  input  logic [ST_W-1:0]     sts_wdata,
  output logic [ST_W-1:0]     status,
  output logic                irq
);
  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  logic       rx_full, rx_empty, tx_full, tx_empty, age_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  sio_fifo #(.W(RW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n_i), .push(rx_push),
    .wdata({rx_par_err, rx_frm_err, rx_data}), .pop(rx_pop),
    .rdata(rx_rdata), .count(rx_level), .full(rx_full), .empty(rx_empty)
  );

  sio_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n_i), .push(tx_push), .wdata(tx_wdata),
    .pop(tx_pop), .rdata(tx_data), .count(tx_level), .full(tx_full),
    .empty(tx_empty)
  );

  sio_age_timer #(.AGE_TICKS(AGE_TICKS)) u_age (
    .clk(clk), .rst_n(rst_n_i), .tick(char_tick),
    .restart(rx_push | rx_pop), .occupied(~rx_empty), .hit(age_hit)
  );

  sio_status #(.CW(CW)) u_sts (
    .clk(clk), .rst_n(rst_n_i), .rx_cnt(rx_level), .tx_cnt(tx_level),
    .rx_thr(cfg_rx_thr), .tx_thr(cfg_tx_thr), .age_ev(age_hit),
    .brk_ev(rx_break), .rx_ovr_ev(rx_push & rx_full),
    .tx_ovf_ev(tx_push & tx_full), .clr_wr(sts_wr), .clr_mask(sts_wdata),
    .irq_en(irq_en), .status(status), .irq(irq)
  );

  assign data_ready = ~rx_empty;
  assign tx_valid   = ~tx_empty;
endmodule

// File: rtl/sio_fifo_svc_chk.sv
module sio_fifo_svc_chk #(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_push,
  input logic          rx_pop,
  input logic          rx_break,
  input logic [CW-1:0] rx_level,
  input logic          tx_push,
  input logic          tx_pop,
  input logic [CW-1:0] tx_level,
  input logic [3:0]    irq_en,
  input logic          sts_wr,
  input logic [5:0]    sts_wdata,
  input logic [5:0]    status,
  input logic          irq
);
  a_r8_rx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !rx_pop && rx_level == CW'(DEPTH)) |=> (status[4] && rx_level == CW'(DEPTH)));

  a_r9_tx_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && !tx_pop && tx_level == CW'(DEPTH)) |=> (status[5] && tx_level == CW'(DEPTH)));

  a_r5_break_latch: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |=> status[3]);

  a_r6_clear_break: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && sts_wdata[3] && !rx_break) |=> !status[3]);

  a_r4_age_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> ($past(rx_level) != '0));

  a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 4'b0000) |-> !irq);

  a_r1_rx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= CW'(DEPTH));
endmodule

bind sio_fifo_svc sio_fifo_svc_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/sio_fifo_svc_tb.sv
module sio_fifo_svc_tb;
  localparam int DEPTH = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_push = 0, rx_frm_err = 0, rx_par_err = 0, rx_break = 0, char_tick = 0, rx_pop = 0;
  logic [7:0] rx_data = 0, tx_wdata = 0;
  logic tx_push = 0, tx_pop = 0, sts_wr = 0;
  logic [5:0] cfg_rx_thr = 6'd24, cfg_tx_thr = 6'd8, sts_wdata = 0;
  logic [3:0] irq_en = 0;
  logic [9:0] rx_rdata;
  logic [5:0] rx_level, tx_level, status;
  logic [7:0] tx_data;
  logic data_ready, tx_valid, irq;
  int total = 0, fails = 0;

  always #5 clk = ~clk;

  sio_fifo_svc u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    rx_push = 0; rx_pop = 0; rx_break = 0; char_tick = 0;
    tx_push = 0; tx_pop = 0; sts_wr = 0;
  endtask

  task automatic clear_all();
    sts_wr = 1; sts_wdata = 6'h3f; step();
  endtask

  function automatic logic [9:0] rx_exp(input int i);
    return {i[1], i[0], 8'(i * 7 + 3)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(rx_level == 0 && tx_level == 0, "reset levels", rx_level, 0);
    chk(status == 6'b000100, "R3 reset status", status, 4);
    chk(!data_ready && !tx_valid && !irq, "R10 reset flags", data_ready, 0);

    // receive fill sweep
    for (int i = 0; i < DEPTH; i++) begin
      rx_push = 1; rx_data = 8'(i * 7 + 3); rx_frm_err = i[0]; rx_par_err = i[1];
      step();
      chk(status[0] == (i + 1 >= 24), "R2 rx ready", status[0], int'(i + 1 >= 24));
      chk(data_ready && rx_level == 6'(i + 1), "R10 data ready", rx_level, i + 1);
    end
    // overrun concurrent with its clear: set wins
    rx_push = 1; rx_data = 8'hEE; sts_wr = 1; sts_wdata = 6'b010000; step();
    chk(status[4] == 1, "R6 overrun set wins", status[4], 1);
    chk(rx_level == 32 && rx_rdata == rx_exp(0), "R8 overrun discards", rx_rdata, rx_exp(0));
    sts_wr = 1; sts_wdata = 6'b010000; step();
    chk(status[4] == 0, "R6 overrun clear", status[4], 0);
    for (int i = 0; i < DEPTH; i++) begin
      chk(rx_rdata == rx_exp(i), "R1 rx order", rx_rdata, rx_exp(i));
      rx_pop = 1; step();
    end
    chk(!data_ready && rx_level == 0, "R10 empty", rx_level, 0);
    rx_pop = 1; step();
    chk(rx_level == 0, "R1 pop empty", rx_level, 0);

    // aging
    clear_all();
    repeat (10) begin char_tick = 1; step(); end
    chk(status[1] == 0, "R4 no aging while empty", status[1], 0);
    rx_push = 1; rx_data = 8'h11; step();
    for (int t = 1; t <= 8; t++) begin
      char_tick = 1; step();
      chk(status[1] == (t == 8), "R4 aging count", status[1], int'(t == 8));
    end
    irq_en = 4'b0010; @(posedge clk); @(negedge clk);
    chk(irq == 1, "R7 aging irq", irq, 1);
    irq_en = 0;
    clear_all();
    chk(status[1] == 0, "R6 aging clear", status[1], 0);
    repeat (7) begin char_tick = 1; step(); end
    rx_push = 1; rx_data = 8'h22; char_tick = 1; step();
    chk(status[1] == 0, "R4 push restarts", status[1], 0);
    repeat (7) begin char_tick = 1; step(); end
    chk(status[1] == 0, "R4 restart 7 ticks", status[1], 0);
    char_tick = 1; step();
    chk(status[1] == 1, "R4 restart 8 ticks", status[1], 1);
    rx_pop = 1; step(); rx_pop = 1; step();
    clear_all();

    // break and same-cycle clear
    rx_break = 1; sts_wr = 1; sts_wdata = 6'b001000; step();
    chk(status[3] == 1, "R5 break set wins", status[3], 1);
    repeat (3) step();
    chk(status[3] == 1, "R5 break sticky", status[3], 1);
    sts_wr = 1; sts_wdata = 6'b000101; step();
    chk(status[3] == 1 && status[2] == 1, "R6 level bits ignore write", status, 12);

    // interrupt enable sweep: pending = break and tx ready
    for (int e = 0; e < 16; e++) begin
      irq_en = 4'(e); @(posedge clk); @(negedge clk);
      chk(irq == (e[3] | e[2]), "R7 irq gating", irq, int'(e[3] | e[2]));
    end
    irq_en = 0;
    sts_wr = 1; sts_wdata = 6'b001000; step();
    chk(status[3] == 0, "R5 break cleared", status[3], 0);

    // transmit sweep
    for (int i = 0; i < DEPTH; i++) begin
      tx_push = 1; tx_wdata = 8'(i * 13 + 5); step();
      chk(status[2] == (i + 1 <= 8), "R3 tx ready", status[2], int'(i + 1 <= 8));
    end
    tx_push = 1; tx_wdata = 8'hAA; step();
    chk(status[5] == 1 && tx_level == 32, "R9 tx overflow", tx_level, 32);
    for (int i = 0; i < DEPTH; i++) begin
      chk(tx_valid && tx_data == 8'(i * 13 + 5), "R11 tx order", tx_data, (i * 13 + 5) % 256);
      tx_pop = 1; step();
    end
    tx_pop = 1; step();
    chk(!tx_valid && tx_level == 0, "R11 pop empty", tx_level, 0);
    clear_all();
    chk(status == 6'b000100, "R6 clear all", status, 4);

    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule